// File: doc/BRIEF.md
# Four-State Hard-Decision Viterbi Decoder

This block recovers the information bits from a stream of hard-decision code symbols. The symbols come from a rate-1/2 convolutional encoder with two delay cells. For an input bit u and the two bits held before it, u1 (the newer one) and u2 (the older one), the encoder sends the pair (u xor u1 xor u2, u xor u2). The decoder accepts one 2-bit symbol per clock when the source offers one. It scores each symbol against the four possible code pairs by Hamming distance. Four add-compare-select cells update one path metric per state and record one survivor decision per state.

A short survivor window holds those decisions. On every accepted symbol, a trace-back starts at the state with the best metric and walks the window back to produce one decoded bit. The decoded bit therefore lags its symbol by a fixed number of symbols. A synchronous reset restarts the trellis from the all-zero encoder state. An upstream demodulator feeds the block, and a downstream consumer takes one bit whenever the valid flag is high.

Top module: `vit4_decoder`

## Requirements
- R1: While reset is high, in_ready and out_valid are 0. From the first cycle after reset is released, in_ready is 1. A symbol is taken on a clock edge where in_valid and in_ready are both 1.
- R2: in_sym[1] carries the first code bit (u^u1^u2) and in_sym[0] carries the second (u^u2). The cost of a branch is the Hamming distance, from 0 to 2, between in_sym and the code pair of that branch.
- R3: State {u1,u2} has the predecessors {u2,0} and {u2,1}. Each state keeps the predecessor with the lower sum of metric and branch cost, and picks the one whose older bit is 0 when the sums are equal. It records that older bit as its decision.
- R4: After reset the metric of state 00 is 0 and the other three metrics are 48, so decoding starts from the all-zero encoder state.
- R5: Path metrics are 6 bits wide. When all four updated metrics are 32 or more, 32 is subtracted from each of them. No metric or candidate sum ever wraps.
- R6: Trace-back starts from the state with the lowest metric, and the lowest index wins a tie.
- R7: No decoded bit appears before 16 symbols have been taken. The bit for symbol k appears on out_bit with out_valid high one cycle after the edge that takes symbol k+15. The bits come out in order, one per accepted symbol.
- R8: The symbols 11,10,00,01,10,01,11 followed by 00 symbols decode to 1,0,1,1,1,0,0 and then zeros.
- R9: The symbols 11,11,00,01,10,00,11 contain two bit errors. Followed by 00 symbols, they still decode to 1,0,1,1,1,0,0.
- R10: A long random stream with one flipped bit in every 17 symbols decodes without error.
- R11: Cycles without an accepted symbol leave the metrics and window unchanged and produce no output.
- R12: A reset in the middle of a stream discards the window and the metrics, and decoding restarts with the full fill delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A received symbol is offered |
| in_ready | output | 1 | The decoder can take a symbol |
| in_sym | input | 2 | Received hard-decision pair, first code bit in bit 1 |
| out_valid | output | 1 | out_bit holds a decoded bit this cycle |
| out_bit | output | 1 | Decoded information bit |

## Verification
The bench targets the fill boundary. It checks for silence after exactly 15 symbols and for the first bit one cycle after the 16th symbol is taken. A wrong window depth or an extra register stage would shift every bit against the scoreboard. Inputs with two errors, and a long run with scattered errors, expose a swapped tap, a wrong decision index or a reversed compare, because any of these turns the corrections into wrong bits. The long run also pushes the metrics through renormalisation many times, where a wrapping metric would swing the best-state choice. Idle gaps and a mid-stream reset catch a trellis that advances without a symbol or keeps stale history.

// File: rtl/vit4_pkg.sv
package vit4_pkg;

  localparam int NSTATE = 4;
  localparam int BM_W   = 2;
  localparam int MAX_BM = 2;

  typedef logic [1:0] state_t;

  // Code pair emitted when bit u enters an encoder whose state is st = {u1,u2}
  function automatic logic [1:0] branch_code(state_t st, logic u);
    return {u ^ st[1] ^ st[0], u ^ st[0]};
  endfunction

  // Distance between two 2-bit pairs
  function automatic logic [BM_W-1:0] hamming2(logic [1:0] a, logic [1:0] b);
    logic [1:0] x;
    x = a ^ b;
    return {1'b0, x[1]} + {1'b0, x[0]};
  endfunction

  // Predecessor of state ns whose older register bit is 'oldest'
  function automatic state_t pred_state(state_t ns, logic oldest);
    return {ns[0], oldest};
  endfunction

endpackage

// File: rtl/vit4_bmu.sv
module vit4_bmu
  import vit4_pkg::*;
(
  input  logic [1:0]                    rx,
  output logic [NSTATE-1:0][BM_W-1:0]   bm_all
);

  // One distance per possible code pair value
  for (genvar v = 0; v < NSTATE; v++) begin : g_pair
    assign bm_all[v] = hamming2(rx, 2'(v));
  end

endmodule

// File: rtl/vit4_acs.sv
module vit4_acs
  import vit4_pkg::*;
#(
  parameter int PM_W   = 6,
  parameter int NS_IDX = 0
)(
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NSTATE-1:0][PM_W-1:0]     pm_all,
  input  logic [NSTATE-1:0][BM_W-1:0]     bm_all,
  output logic [PM_W-1:0]                 pm_out,
  output logic                            dec_out
);

  localparam int     CW = PM_W + 1;
  localparam state_t NS = state_t'(NS_IDX);

  state_t          pred0, pred1;
  logic [CW-1:0]   cand0, cand1;
  logic            take1;

  always_comb begin
    pred0   = pred_state(NS, 1'b0);
    pred1   = pred_state(NS, 1'b1);
    cand0   = CW'(pm_all[pred0]) + CW'(bm_all[branch_code(pred0, NS[1])]);
    cand1   = CW'(pm_all[pred1]) + CW'(bm_all[branch_code(pred1, NS[1])]);
    take1   = cand1 < cand0;          // equal sums keep the older-bit-0 branch
    pm_out  = take1 ? cand1[PM_W-1:0] : cand0[PM_W-1:0];
    dec_out = take1;
  end

  AST_CAND_FITS: assert property (@(posedge clk) disable iff (rst)
    !cand0[PM_W] && !cand1[PM_W]);                                   // R5

endmodule

// File: rtl/vit4_tbu.sv
module vit4_tbu
  import vit4_pkg::*;
#(
  parameter int TRUNC = 15
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [NSTATE-1:0]  dec_in,
  input  state_t             best_in,
  output logic               out_valid,
  output logic               out_bit
);

  localparam int DEPTH = TRUNC - 1;          // decision vectors kept
  localparam int CNT_W = $clog2(TRUNC + 1);

  logic [NSTATE-1:0] surv [DEPTH];
  logic [CNT_W-1:0]  fill_cnt;
  logic              window_full;
  logic              trace_go;
  state_t            walk [DEPTH];
  logic              traced_bit;

  assign window_full = (fill_cnt == CNT_W'(TRUNC));

  // Trace-back: walk[j] is the state j steps before the newest one
  assign walk[0] = best_in;
  for (genvar j = 0; j < DEPTH - 1; j++) begin : g_walk
    assign walk[j+1] = pred_state(walk[j], surv[j][walk[j]]);
  end
  // Oldest decision names the older bit of the predecessor: the bit leaving the window
  assign traced_bit = surv[DEPTH-1][walk[DEPTH-1]];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) surv[i] <= '0;
      fill_cnt  <= '0;
      trace_go  <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      trace_go  <= accept && window_full;
      out_valid <= trace_go;
      out_bit   <= traced_bit;
      if (accept) begin
        surv[0] <= dec_in;
        for (int i = 1; i < DEPTH; i++) surv[i] <= surv[i-1];
        if (!window_full) fill_cnt <= fill_cnt + 1'b1;
      end
    end
  end

  AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(accept, 2));                                  // R7

endmodule

// File: rtl/vit4_decoder.sv
module vit4_decoder
  import vit4_pkg::*;
#(
  parameter int PM_W  = 6,
  parameter int TRUNC = 15
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [1:0]  in_sym,
  output logic        out_valid,
  output logic        out_bit
);

  localparam int              PM_INIT_I = (1 << PM_W) - (1 << (PM_W - 2));
  localparam int              PM_CEIL_I = PM_INIT_I + 2 * MAX_BM;
  localparam logic [PM_W-1:0] PM_INIT   = PM_W'(PM_INIT_I);
  localparam logic [PM_W-1:0] PM_CEIL   = PM_W'(PM_CEIL_I);
  localparam logic [PM_W-1:0] NORM      = PM_W'(1 << (PM_W - 1));

  logic                           accept;
  logic [NSTATE-1:0][BM_W-1:0]    bm_all;
  logic [NSTATE-1:0][PM_W-1:0]    pm_q, pm_new, pm_d;
  logic [NSTATE-1:0]              dec;
  logic                           all_high;
  logic                           norm_evt;
  state_t                         best;
  logic [PM_W-1:0]                best_pm;

  assign accept = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) in_ready <= 1'b0;
    else     in_ready <= 1'b1;
  end

  vit4_bmu u_bmu (
    .rx     (in_sym),
    .bm_all (bm_all)
  );

  for (genvar s = 0; s < NSTATE; s++) begin : g_acs
    vit4_acs #(.PM_W(PM_W), .NS_IDX(s)) u_acs (
      .clk     (clk),
      .rst     (rst),
      .pm_all  (pm_q),
      .bm_all  (bm_all),
      .pm_out  (pm_new[s]),
      .dec_out (dec[s])
    );
  end

  // Renormalise only when every metric is at or above NORM
  always_comb begin
    all_high = 1'b1;
    for (int s = 0; s < NSTATE; s++) all_high &= pm_new[s][PM_W-1];
    norm_evt = accept && all_high;
    for (int s = 0; s < NSTATE; s++)
      pm_d[s] = all_high ? (pm_new[s] - NORM) : pm_new[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSTATE; s++) pm_q[s] <= (s == 0) ? '0 : PM_INIT;
    end else if (accept) begin
      pm_q <= pm_d;
    end
  end

  // Lowest metric; strict compare keeps the lowest index on ties
  always_comb begin
    best    = '0;
    best_pm = pm_q[0];
    for (int s = 1; s < NSTATE; s++) begin
      if (pm_q[s] < best_pm) begin
        best    = state_t'(s);
        best_pm = pm_q[s];
      end
    end
  end

  vit4_tbu #(.TRUNC(TRUNC)) u_tbu (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .dec_in    (dec),
    .best_in   (best),
    .out_valid (out_valid),
    .out_bit   (out_bit)
  );

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> in_ready);                                        // R1
  AST_START_METRICS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pm_q[0] == '0) && (pm_q[1] == PM_INIT) && (pm_q[2] == PM_INIT) && (pm_q[3] == PM_INIT)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (pm_q[0] <= PM_CEIL) && (pm_q[1] <= PM_CEIL) && (pm_q[2] <= PM_CEIL) && (pm_q[3] <= PM_CEIL)); // R5
  AST_NORM_APPLIED: assert property (@(posedge clk) disable iff (rst)
    norm_evt |=> (pm_q[0] < NORM));                                   // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(pm_q));                                       // R11

endmodule

// File: tb/test_vit4_decoder.sv
module test_vit4_decoder;

  localparam int TRUNC = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] in_sym = 2'b00;
  logic       in_ready, out_valid, out_bit;

  int    checks = 0;
  int    fails  = 0;
  int    outs   = 0;
  bit    sb[$];
  string cur_req = "R8";
  logic [1:0] enc_st = 2'b00;

  always #4 clk = ~clk;   // 125 MHz

  vit4_decoder i_vit4_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym(in_sym), .out_valid(out_valid), .out_bit(out_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference encoder written as tap masks over the window {u, u1, u2}
  function automatic logic [1:0] ref_enc(bit u, logic [1:0] st);
    logic [2:0] win;
    win = {u, st};
    return {^(win & 3'b111), ^(win & 3'b101)};
  endfunction

  // Monitor: pops the scoreboard on each decoded bit
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      outs++;
      if (sb.size() == 0) check(1'b0, cur_req, int'(out_bit), -1);
      else begin
        automatic bit exp = sb.pop_front();
        check(out_bit == exp, cur_req, int'(out_bit), int'(exp));
      end
    end
  end

  task automatic send_bit(input bit u, input logic [1:0] flip);
    in_sym   = ref_enc(u, enc_st) ^ flip;
    enc_st   = {u, enc_st[1]};
    in_valid = 1'b1;
    sb.push_back(u);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    idle(3);
    check(in_ready == 1'b0, "R1 ready in reset", int'(in_ready), 0);
    check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    sb.delete();
    enc_st = 2'b00;
    rst = 1'b0;
    idle(1);
    check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    bit ex [7] = '{1, 0, 1, 1, 1, 0, 0};
    logic [1:0] noise [7] = '{2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b01, 2'b00};
    int snap;

    do_reset();

    // R7 fill boundary, R4 start state, R8 clean example
    cur_req = "R8 R4 (R2 R3 R6)";
    for (int i = 0; i < 7; i++) send_bit(ex[i], 2'b00);
    for (int i = 0; i < 8; i++) send_bit(1'b0, 2'b00);
    idle(4);
    check(outs == 0, "R7 silent after 15 symbols", outs, 0);
    send_bit(1'b0, 2'b00);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 not yet valid", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R7 first bit valid", int'(out_valid), 1);
    check(out_bit == 1'b1, "R4 R7 first decoded bit", int'(out_bit), 1);
    #1;
    for (int i = 0; i < 14; i++) send_bit(1'b0, 2'b00);
    idle(3);
    check(outs == 15, "R8 bit count", outs, 15);

    // R11 idle cycles
    cur_req = "R11";
    snap = outs;
    idle(8);
    check(outs == snap, "R11 no output while idle", outs, snap);
    for (int i = 0; i < 5; i++) begin send_bit(1'b1, 2'b00); idle(2); end
    idle(3);
    check(outs == snap + 5, "R11 one bit per symbol with gaps", outs, snap + 5);

    // R9 two-error example
    do_reset();
    cur_req = "R9";
    snap = outs;
    for (int i = 0; i < 7; i++) send_bit(ex[i], noise[i]);
    for (int i = 0; i < TRUNC; i++) send_bit(1'b0, 2'b00);
    idle(3);
    check(outs == snap + 7, "R9 bit count", outs - snap, 7);

    // R12 reset mid-stream
    cur_req = "R12";
    for (int i = 0; i < 10; i++) send_bit(1'(i % 3 == 0), 2'b00);
    do_reset();
    check(out_valid == 1'b0, "R12 no output after reset", int'(out_valid), 0);
    snap = outs;
    for (int i = 0; i < TRUNC; i++) send_bit(1'(i % 2), 2'b00);
    idle(4);
    check(outs == snap, "R12 fill delay restarted", outs - snap, 0);

    // R10 long random stream with scattered errors, also drives R5 renormalisation
    do_reset();
    cur_req = "R10 R5";
    snap = outs;
    for (int i = 0; i < 1200; i++) begin
      automatic logic [1:0] f = (i % 17 == 8) ? ((i % 2 != 0) ? 2'b10 : 2'b01) : 2'b00;
      send_bit(1'($urandom % 2), f);
      if ($urandom % 4 == 0) idle(1);
    end
    for (int i = 0; i < TRUNC; i++) send_bit(1'b0, 2'b00);
    idle(4);
    check(outs == snap + 1200, "R10 bit count", outs - snap, 1200);
    check(sb.size() == TRUNC, "R7 bits held in window", sb.size(), TRUNC);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule